// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block computes 8, 16 or 32-bit integer results from two operands, an operation selector and a size selector. The result path is combinational. A twelve-bit flags word sits in a register beside it. The carry bit of that register acts as the carry-in and borrow-in, so a wide word can be processed as a series of word-sized steps. Examples are a low add followed by a high add-with-carry, or a high logical right shift followed by a low rotate right through carry.

The flags register changes only on request. A load strobe restores a saved flags word, and an update strobe commits the flags of the current operation. Data moves and the bitwise complement leave every flag alone even when the update strobe is set. Compare and test commit flags but lower the write-enable, so the caller discards their result.

Top module: `alu_status_unit`

## Requirements
- R1: `op_sel` encodes 0 move, 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-borrow, 5 increment, 6 decrement, 7 negate, 8 compare, 9 and, 10 or, 11 xor, 12 complement, 13 test, 14 shift left, 15 logical shift right, 16 arithmetic shift right, 17 rotate left, 18 rotate right, 19 rotate left through carry, 20 rotate right through carry. `size_sel` encodes 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. The operands are truncated to the selected size, and `result` bits above that size are zero.
- R2: Add-with-carry adds the stored carry flag. Subtract-with-borrow also subtracts it. Add, subtract, negate and compare use no carry-in.
- R3: The flags word places carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow at bit 11. Bits 1, 3 and 5 always read 0. Bits 8 to 10 change only through a load.
- R4: After an add, carry is the carry out of the most significant bit of the selected size. After a subtract, compare or negate, carry is the borrow. Negate sets carry exactly when the operand is nonzero.
- R5: Zero and sign reflect the result truncated to the selected size. Parity is 1 when the low 8 result bits hold an even number of ones.
- R6: For arithmetic operations, auxiliary carry is the carry or borrow between bit 3 and bit 4.
- R7: For arithmetic operations, overflow is set when the two's-complement result does not fit in the selected size.
- R8: Increment and decrement update zero, sign, parity, auxiliary carry and overflow, and keep the carry flag.
- R9: And, or, xor and test clear carry, overflow and auxiliary carry, and set zero, sign and parity from the result. Complement changes no flag.
- R10: Single-bit shifts and rotates put the bit moved out in carry. The rotates through carry move the old carry into the vacated bit. Overflow is the new top bit xor the new carry after left moves, and the new top two bits xored after right rotates. It is the old top bit for a logical right shift and 0 for an arithmetic right shift. Shifts also set zero, sign and parity and clear auxiliary carry. Rotates leave those four flags unchanged.
- R11: Compare and test set the flags that subtract and and would set, and drive `wr_en` low. Every other operation drives `wr_en` high.
- R12: Move returns the second operand truncated to size and changes no flag, even with `upd_en` high.
- R13: Reset clears the flags register. `load_en` writes `load_val` with bits 1, 3 and 5 forced to 0, and takes precedence over `upd_en`. With both strobes low the flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | DATA_W | First operand (destination value) |
| b_in | input | DATA_W | Second operand (source value) |
| op_sel | input | 5 | Operation code |
| size_sel | input | 2 | Operand size select |
| upd_en | input | 1 | Commit this operation's flags on the next edge |
| load_en | input | 1 | Load `load_val` into the flags register |
| load_val | input | 12 | Flags word to restore |
| result | output | DATA_W | Combinational result, zero above the size |
| wr_en | output | 1 | Result should be written to the destination |
| flags_q | output | 12 | Registered flags word |

## Verification
The bound checker watches the properties that hold on every cycle. The flags hold when no strobe is set, a load lands masked, the reserved bits stay zero and the control bits move only on a load. It also checks that move and the increment/decrement carry leave flags intact, that logical operations clear carry, overflow and auxiliary carry, that parity follows the committed result, that `wr_en` is low for compare and test, and that the result is zero above an 8-bit size. Exact arithmetic values can only be shown by the bench's scenarios, which compare each operation against an independent model. These values include the carry and overflow edges at each size, chained 64-bit add, subtract and shift sequences, and the rotate-through-carry bit flow.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FLAG_W = 12;
  localparam int CF_B = 0;
  localparam int PF_B = 2;
  localparam int AF_B = 4;
  localparam int ZF_B = 6;
  localparam int SF_B = 7;
  localparam int OF_B = 11;
  // bits that exist in the flags word; 1, 3 and 5 are reserved
  localparam logic [FLAG_W-1:0] FLAG_MASK = 12'hFD5;

  typedef enum logic [4:0] {
    OP_MOV = 5'd0,  OP_ADD = 5'd1,  OP_ADC = 5'd2,  OP_SUB = 5'd3,
    OP_SBB = 5'd4,  OP_INC = 5'd5,  OP_DEC = 5'd6,  OP_NEG = 5'd7,
    OP_CMP = 5'd8,  OP_AND = 5'd9,  OP_OR  = 5'd10, OP_XOR = 5'd11,
    OP_NOT = 5'd12, OP_TST = 5'd13, OP_SHL = 5'd14, OP_SHR = 5'd15,
    OP_SAR = 5'd16, OP_ROL = 5'd17, OP_ROR = 5'd18, OP_RCL = 5'd19,
    OP_RCR = 5'd20
  } alu_op_e;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  y,
  input  logic          cin,
  input  logic          sub,
  input  logic [W-1:0]  mask,
  input  logic [IW-1:0] msb,
  output logic [W-1:0]  sum,
  output logic          cout,
  output logic          aux,
  output logic          ovf
);
  logic [W-1:0] y_eff;
  logic [W:0]   full;
  logic [IW:0]  cidx;

  always_comb begin
    y_eff = sub ? (~y & mask) : y;
    full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, (sub ? ~cin : cin)};
    sum   = full[W-1:0] & mask;
    cidx  = {1'b0, msb} + {{IW{1'b0}}, 1'b1};
    // inverted carry of a subtract is the borrow
    cout  = full[cidx] ^ sub;
    aux   = x[4] ^ y[4] ^ sum[4];
    ovf   = (x[msb] == y_eff[msb]) && (sum[msb] != x[msb]);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter import alu_pkg::*; #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  logic          cin,
  input  alu_op_e       op,
  input  logic [W-1:0]  mask,
  input  logic [IW-1:0] msb,
  output logic [W-1:0]  res,
  output logic          cout,
  output logic          ovf
);
  logic [W-1:0] top_bit;
  logic [IW-1:0] nxt_msb;

  always_comb begin
    top_bit = {{(W-1){1'b0}}, 1'b1} << msb;
    nxt_msb = msb - {{(IW-1){1'b0}}, 1'b1};
    res  = x;
    cout = 1'b0;
    ovf  = 1'b0;
    case (op)
      OP_SHL: begin
        res  = (x << 1) & mask;
        cout = x[msb];
        ovf  = res[msb] ^ x[msb];
      end
      OP_SHR: begin
        res  = x >> 1;
        cout = x[0];
        ovf  = x[msb];
      end
      OP_SAR: begin
        res  = (x >> 1) | (x & top_bit);
        cout = x[0];
      end
      OP_ROL, OP_RCL: begin
        res  = ((x << 1) | {{(W-1){1'b0}}, (op == OP_ROL) ? x[msb] : cin}) & mask;
        cout = x[msb];
        ovf  = res[msb] ^ x[msb];
      end
      OP_ROR, OP_RCR: begin
        res  = (x >> 1) | ((((op == OP_ROR) ? x[0] : cin)) ? top_bit : '0);
        cout = x[0];
        ovf  = res[msb] ^ res[nxt_msb];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg import alu_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [FLAG_W-1:0] load_val,
  input  logic              upd_en,
  input  logic [FLAG_W-1:0] nxt,
  output logic [FLAG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_en) q <= load_val & FLAG_MASK;
    else if (upd_en)  q <= nxt & FLAG_MASK;
  end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit import alu_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [4:0]        op_sel,
  input  logic [1:0]        size_sel,
  input  logic              upd_en,
  input  logic              load_en,
  input  logic [FLAG_W-1:0] load_val,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [FLAG_W-1:0] flags_q
);
  localparam int IW = $clog2(DATA_W);

  alu_op_e           op;
  logic [DATA_W-1:0] mask, a_m, b_m;
  logic [IW-1:0]     msb;
  logic [DATA_W-1:0] ad_x, ad_y, ad_sum, sh_res, res_c;
  logic              ad_cin, ad_sub, ad_c, ad_aux, ad_ovf, sh_c, sh_ovf, szp_en;
  logic [FLAG_W-1:0] flags_nx;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    case (size_sel)
      2'd0: begin mask = {{(DATA_W-8){1'b0}}, 8'hFF};    msb = IW'(7);  end
      2'd1: begin mask = {{(DATA_W-16){1'b0}}, 16'hFFFF}; msb = IW'(15); end
      default: begin mask = '1; msb = IW'(DATA_W-1); end
    endcase
    a_m = a_in & mask;
    b_m = b_in & mask;
  end

  // adder operand selection
  always_comb begin
    ad_x = a_m; ad_y = b_m; ad_sub = 1'b0; ad_cin = 1'b0;
    case (op)
      OP_ADC:         ad_cin = flags_q[CF_B];
      OP_SUB, OP_CMP: ad_sub = 1'b1;
      OP_SBB: begin ad_sub = 1'b1; ad_cin = flags_q[CF_B]; end
      OP_INC: ad_y = {{(DATA_W-1){1'b0}}, 1'b1};
      OP_DEC: begin ad_y = {{(DATA_W-1){1'b0}}, 1'b1}; ad_sub = 1'b1; end
      OP_NEG: begin ad_x = '0; ad_y = a_m; ad_sub = 1'b1; end
      default: ;
    endcase
  end

  alu_adder #(.W(DATA_W)) u_add (
    .x(ad_x), .y(ad_y), .cin(ad_cin), .sub(ad_sub), .mask(mask), .msb(msb),
    .sum(ad_sum), .cout(ad_c), .aux(ad_aux), .ovf(ad_ovf)
  );

  alu_shifter #(.W(DATA_W)) u_shf (
    .x(a_m), .cin(flags_q[CF_B]), .op(op), .mask(mask), .msb(msb),
    .res(sh_res), .cout(sh_c), .ovf(sh_ovf)
  );

  // result and next flags
  always_comb begin
    res_c    = b_m;
    flags_nx = flags_q;
    szp_en   = 1'b0;
    wr_en    = (op != OP_CMP) && (op != OP_TST);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG, OP_CMP: begin
        res_c = ad_sum; szp_en = 1'b1;
        flags_nx[CF_B] = ad_c; flags_nx[AF_B] = ad_aux; flags_nx[OF_B] = ad_ovf;
      end
      OP_INC, OP_DEC: begin
        res_c = ad_sum; szp_en = 1'b1;
        flags_nx[AF_B] = ad_aux; flags_nx[OF_B] = ad_ovf;
      end
      OP_AND, OP_TST, OP_OR, OP_XOR: begin
        res_c = (op == OP_OR)  ? (a_m | b_m) :
                (op == OP_XOR) ? (a_m ^ b_m) : (a_m & b_m);
        szp_en = 1'b1;
        flags_nx[CF_B] = 1'b0; flags_nx[AF_B] = 1'b0; flags_nx[OF_B] = 1'b0;
      end
      OP_NOT: res_c = ~a_in & mask;
      OP_SHL, OP_SHR, OP_SAR: begin
        res_c = sh_res; szp_en = 1'b1;
        flags_nx[CF_B] = sh_c; flags_nx[AF_B] = 1'b0; flags_nx[OF_B] = sh_ovf;
      end
      OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
        res_c = sh_res;
        flags_nx[CF_B] = sh_c; flags_nx[OF_B] = sh_ovf;
      end
      default: ;
    endcase
    if (szp_en) begin
      flags_nx[ZF_B] = (res_c == '0);
      flags_nx[SF_B] = res_c[msb];
      flags_nx[PF_B] = ~^res_c[7:0];
    end
  end

  assign result = res_c;

  alu_flag_reg u_flg (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .upd_en(upd_en), .nxt(flags_nx), .q(flags_q)
  );
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk import alu_pkg::*; #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        op_sel,
  input logic [1:0]        size_sel,
  input logic              upd_en,
  input logic              load_en,
  input logic [FLAG_W-1:0] load_val,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic [FLAG_W-1:0] flags_q
);
  logic is_logic, is_szp, commit;
  assign is_logic = (op_sel == OP_AND) || (op_sel == OP_OR) || (op_sel == OP_XOR) || (op_sel == OP_TST);
  assign is_szp   = is_logic || ((op_sel >= OP_ADD) && (op_sel <= OP_CMP));
  assign commit   = upd_en && !load_en;

  // R13
  hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_en && !load_en) |=> flags_q == $past(flags_q));
  // R13
  load_flags_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> flags_q == ($past(load_val) & FLAG_MASK));
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_q & ~FLAG_MASK) == '0);
  // R3
  ctrl_bits_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> flags_q[10:8] == $past(flags_q[10:8]));
  // R11
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en == !((op_sel == OP_CMP) || (op_sel == OP_TST)));
  // R12
  mov_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && op_sel == OP_MOV) |=> flags_q == $past(flags_q));
  // R1
  narrow_result_chk: assert property (@(posedge clk) disable iff (rst)
    (size_sel == 2'd0) |-> result[DATA_W-1:8] == '0);
  // R8
  incdec_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && (op_sel == OP_INC || op_sel == OP_DEC)) |=> flags_q[CF_B] == $past(flags_q[CF_B]));
  // R9
  logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && is_logic) |=> (!flags_q[CF_B] && !flags_q[OF_B] && !flags_q[AF_B]));
  // R5
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && is_szp) |=> flags_q[PF_B] == ~^$past(result[7:0]));
endmodule

bind alu_status_unit alu_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .size_sel(size_sel), .upd_en(upd_en),
  .load_en(load_en), .load_val(load_val), .result(result), .wr_en(wr_en),
  .flags_q(flags_q)
);

// File: tb/test_alu_status_unit.sv
module test_alu_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a_in = '0, b_in = '0;
  logic [4:0]  op_sel = '0;
  logic [1:0]  size_sel = '0;
  logic        upd_en = 1'b0, load_en = 1'b0;
  logic [11:0] load_val = '0;
  logic [31:0] result;
  logic        wr_en;
  logic [11:0] flags_q;

  int n_chk = 0, n_bad = 0;
  logic [11:0] mdl_fl = '0;
  logic [31:0] rng = 32'h1234_5678;

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic [11:0] fl;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  alu_status_unit #(.DATA_W(32)) i_alu_status_unit (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .op_sel(op_sel),
    .size_sel(size_sel), .upd_en(upd_en), .load_en(load_en), .load_val(load_val),
    .result(result), .wr_en(wr_en), .flags_q(flags_q)
  );

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  function automatic string tag_of(input int op);
    if (op == 0) return "R12";
    if (op == 2 || op == 4) return "R2";
    if (op >= 1 && op <= 7) return "R4";
    if (op == 8 || op == 13) return "R11";
    if (op >= 9 && op <= 12) return "R9";
    return "R10";
  endfunction

  // independent reference model
  function automatic void model(input int op, input int sz, input logic [31:0] ai, bi,
                                input logic [11:0] fl, output logic [31:0] res,
                                output logic wr, output logic [11:0] nf);
    int n;
    longint unsigned mask, a, b, r, cin, hb;
    longint sres;
    bit c, af, ov, szp, setc, seta, seto;
    n = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (64'd1 << n) - 1;
    hb = 64'd1 << (n - 1);
    a = ai & mask; b = bi & mask;
    cin = fl[0];
    nf = fl; wr = 1'b1; r = b;
    c = 0; af = 0; ov = 0; szp = 0; setc = 0; seta = 0; seto = 0;
    case (op)
      1, 2, 5: begin
        if (op == 5) begin b = 1; cin = 0; end
        if (op == 1) cin = 0;
        r = (a + b + cin) & mask;
        c = ((a + b + cin) >> n) != 0;
        af = ((a & 15) + (b & 15) + cin) > 15;
        ov = (((a & hb) != 0) == ((b & hb) != 0)) && (((r & hb) != 0) != ((a & hb) != 0));
        szp = 1; seta = 1; seto = 1; setc = (op != 5);
      end
      3, 4, 6, 7, 8: begin
        if (op == 6) b = 1;
        if (op == 7) begin b = a; a = 0; end
        if (op != 4) cin = 0;
        sres = longint'(a) - longint'(b) - longint'(cin);
        r = longint'(sres) & mask;
        c = sres < 0;
        af = (a & 15) < ((b & 15) + cin);
        ov = (((a & hb) != 0) != ((b & hb) != 0)) && (((r & hb) != 0) != ((a & hb) != 0));
        szp = 1; seta = 1; seto = 1; setc = (op != 6);
        wr = (op != 8);
      end
      9, 10, 11, 13: begin
        r = (op == 10) ? (a | b) : (op == 11) ? (a ^ b) : (a & b);
        szp = 1; setc = 1; seta = 1; seto = 1;
        wr = (op != 13);
      end
      12: r = ~a & mask;
      14: begin r = (a << 1) & mask; c = (a & hb) != 0; ov = ((r & hb) != 0) ^ c;
                szp = 1; setc = 1; seta = 1; seto = 1; end
      15: begin r = a >> 1; c = a[0]; ov = (a & hb) != 0;
                szp = 1; setc = 1; seta = 1; seto = 1; end
      16: begin r = (a >> 1) | (a & hb); c = a[0];
                szp = 1; setc = 1; seta = 1; seto = 1; end
      17, 19: begin
        c = (a & hb) != 0;
        r = ((a << 1) | ((op == 17) ? longint'(c) : cin)) & mask;
        ov = ((r & hb) != 0) ^ c; setc = 1; seto = 1;
      end
      18, 20: begin
        c = a[0];
        r = (a >> 1) | ((((op == 18) ? longint'(c) : cin) != 0) ? hb : 0);
        ov = ((r & hb) != 0) ^ ((r & (hb >> 1)) != 0); setc = 1; seto = 1;
      end
      default: ;
    endcase
    res = r[31:0];
    if (setc) nf[0] = c;
    if (seta) nf[4] = af;
    if (seto) nf[11] = ov;
    if (szp) begin
      nf[6] = (r == 0);
      nf[7] = (r & hb) != 0;
      nf[2] = ($countones(r & 64'hFF) % 2) == 0;
    end
  endfunction

  task automatic drive(input int op, input int sz, input logic [31:0] a, b,
                       input logic upd, input logic ld, input logic [11:0] lv, input string tag);
    item_t it;
    logic [31:0] r;
    logic w;
    logic [11:0] nf;
    @(negedge clk);
    model(op, sz, a, b, mdl_fl, r, w, nf);
    if (ld)       mdl_fl = lv & 12'hFD5;
    else if (upd) mdl_fl = nf;
    it.res = r; it.wr = w; it.fl = mdl_fl; it.tag = tag;
    sb.push_back(it);
    op_sel = 5'(op); size_sel = 2'(sz); a_in = a; b_in = b;
    upd_en = upd; load_en = ld; load_val = lv;
  endtask

  // monitor: result before the edge, flags after it
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if (result !== it.res || wr_en !== it.wr) begin
          n_bad++;
          $display("FAIL %s: result %h wr %b, expected %h wr %b", it.tag, result, wr_en, it.res, it.wr);
        end
        @(posedge clk);
        #1;
        n_chk++;
        if (flags_q !== it.fl) begin
          n_bad++;
          $display("FAIL %s: flags %h, expected %h", it.tag, flags_q, it.fl);
        end
      end
    end
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R13 reset state
    n_chk++;
    if (flags_q !== 12'h000 || result !== 32'h0) begin
      n_bad++;
      $display("FAIL R13: reset flags %h result %h, expected 000 and 0", flags_q, result);
    end
    // R7 R6 8-bit signed overflow and nibble carry
    drive(1, 0, 32'h7F, 32'h01, 1, 0, 0, "R7");
    // R4 R5 8-bit wrap to zero
    drive(1, 0, 32'hFF, 32'h01, 1, 0, 0, "R5");
    // R1 upper operand bits ignored at 16 bits
    drive(1, 1, 32'hABCD_8000, 32'h1111_8000, 1, 0, 0, "R1");
    // R2 64-bit add: low then high with carry
    drive(1, 2, 32'hFFFF_FFFF, 32'h0000_0001, 1, 0, 0, "R2");
    drive(2, 2, 32'h0000_0000, 32'h0000_0000, 1, 0, 0, "R2");
    // R2 64-bit subtract with borrow
    drive(3, 2, 32'h0000_0000, 32'h0000_0001, 1, 0, 0, "R2");
    drive(4, 2, 32'h0000_0005, 32'h0000_0002, 1, 0, 0, "R2");
    // R8 increment keeps carry
    drive(1, 0, 32'hFF, 32'h02, 1, 0, 0, "R8");
    drive(5, 0, 32'h7F, 32'h0, 1, 0, 0, "R8");
    drive(6, 1, 32'h0, 32'h0, 1, 0, 0, "R8");
    // R4 negate of zero and nonzero
    drive(7, 0, 32'h00, 32'h0, 1, 0, 0, "R4");
    drive(7, 2, 32'h8000_0000, 32'h0, 1, 0, 0, "R4");
    // R10 64-bit logical right shift across two words
    drive(15, 2, 32'h0000_0001, 32'h0, 1, 0, 0, "R10");
    drive(20, 2, 32'h0000_0000, 32'h0, 1, 0, 0, "R10");
    drive(16, 0, 32'h81, 32'h0, 1, 0, 0, "R10");
    drive(19, 1, 32'h8000, 32'h0, 1, 0, 0, "R10");
    // R11 compare and test
    drive(8, 2, 32'h10, 32'h20, 1, 0, 0, "R11");
    drive(13, 0, 32'hF0, 32'h0F, 1, 0, 0, "R11");
    // R13 load restores, reserved bits dropped, wins over update
    drive(1, 0, 32'h1, 32'h1, 1, 1, 12'hFFF, "R13");
    // R12 move with update keeps flags; R9 complement keeps flags
    drive(0, 2, 32'h0, 32'hDEAD_BEEF, 1, 0, 0, "R12");
    drive(12, 1, 32'h00FF, 32'h0, 1, 0, 0, "R9");
    // R13 no strobe holds flags
    drive(3, 0, 32'h0, 32'h1, 0, 0, 0, "R13");
    // R9 logic clears carry, overflow, aux
    drive(11, 0, 32'hAA, 32'hAA, 1, 0, 0, "R9");
    // R3 control bits survive arithmetic
    drive(1, 0, 32'h0, 32'h0, 0, 1, 12'h700, "R3");
    drive(3, 0, 32'h0, 32'h1, 1, 0, 0, "R3");
    // mixed scenarios over all codes and sizes
    for (int i = 0; i < 600; i++) begin
      int op, sz;
      logic [31:0] a, b;
      logic u, l;
      op = int'(rnd() % 21);
      sz = int'(rnd() % 3);
      a = rnd(); b = rnd();
      if (i % 7 == 0) b = a;
      u = (rnd() % 8) != 0;
      l = (rnd() % 25) == 0;
      drive(op, sz, a, b, u, l, rnd() [11:0], tag_of(op));
    end
    @(negedge clk);
    upd_en = 1'b0; load_en = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule